// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital half of a successive-approximation converter. A processor reaches it as four 32-bit words on a plain memory-mapped bus: a result word, a status word, a control word and a start-delay word. Software selects one of eight analog inputs and sets the power bit in the control word, optionally with the interrupt enable. The block then counts a programmable start delay, walks a binary search over the trial code one bit per clock, and compares each trial against a one-bit comparator input. At the end it stores the code, drops busy and flags completion.

The comparator itself is outside the block: `trialCode` drives the external DAC and `cmpIn` returns the comparison result. Everything runs on a single clock. Clearing the power bit, usually by writing zero to the control word, switches the converter off and abandons any conversion in flight.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset the result word (byte offset 0x00) reads 0, status (0x04) reads 0, control (0x08) reads 0, the delay word (0x0C) reads 8, and `irqOut`, `anaPwrEn` and `trialCode` are all 0.
- R2: Only the aligned offsets 0x00, 0x04, 0x08 and 0x0C are mapped. Every other offset, including misaligned ones and 0x10 to 0x1C, reads 0 and ignores writes. The result and status words are read-only.
- R3: In the control word, bits [2:0] select the channel and drive `chanSel`, and bit 3 is power and drives `anaPwrEn`. A conversion starts only when a write moves bit 3 from 0 to 1. A write that keeps bit 3 at 1 does not start another conversion.
- R4: The delay word holds 6 bits, D. For a power-up write accepted at clock edge E0, status bit 0 (busy) is 1 from E0 to edge E0+D+RES_W and 0 after edge E0+D+1+RES_W.
- R5: Conversion starts at edge E0+D+1, when the trial code becomes the MSB alone. Each following edge keeps the current trial bit if `cmpIn` is 1 and clears it if not, then sets the next lower bit, from MSB down to LSB.
- R6: The result is RES_W bits wide (10 or 12). It is right-aligned in the result word, the upper bits read 0, and it equals the code resolved by the binary search.
- R7: At the final conversion edge, busy clears, the result word updates and the completion flag (control bit 6) sets, all at the same edge.
- R8: `irqOut` is 1 exactly when the completion flag and the interrupt enable (control bit 5) are both 1. With the enable at 0 the flag still sets, but `irqOut` stays 0.
- R9: A control write with bit 6 at 0 clears the completion flag. A control write with bit 6 at 1 leaves the flag as it was, and software cannot set it.
- R10: A control write with bit 3 at 0 stops the converter at once. Busy reads 0, `trialCode` returns to 0, the completion flag clears, the result word keeps its old value and no completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and converter |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| cmpIn | input | 1 | Comparator result, 1 when the input is at or above the trial code |
| trialCode | output | RES_W | Trial code sent to the DAC, 0 when idle |
| chanSel | output | 3 | Selected analog input |
| anaPwrEn | output | 1 | Power enable for the analog front end |
| irqOut | output | 1 | Completion interrupt |

## Verification
The bench builds the block with RES_W = 12 and the default 6-bit delay. This gives a full 12-step search, so codes at both ends of the range (0x000 and 0xFFF) and alternating bit patterns are reachable. Delays are checked at 0, 1, 2, 8 and the largest value, 63. Each conversion is checked edge by edge to confirm the exact end cycle. Aborts are placed both inside the delay window and inside the search itself.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // Word indices of the mapped registers (byte offset / 4)
  localparam int unsigned WORD_RESULT = 0;
  localparam int unsigned WORD_STATUS = 1;
  localparam int unsigned WORD_CTRL   = 2;
  localparam int unsigned WORD_DELAY  = 3;
  localparam int unsigned NUM_WORDS   = 4;

  // Control word field positions (software visible)
  localparam int unsigned CHAN_W      = 3;
  localparam int unsigned CTRL_PWR    = 3;
  localparam int unsigned CTRL_IEN    = 5;
  localparam int unsigned CTRL_DONE   = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadDly;
    logic decDly;
    logic startConv;
    logic stepConv;
    logic abort;
  } seqStrb_t;

endpackage

// File: rtl/sar_adc_dp.sv
module sar_adc_dp
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned DLY_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrb_t         strb,
  input  logic [DLY_W-1:0] dlyVal,
  input  logic             cmpIn,
  output logic             dlyZero,
  output logic             lastBit,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);

  localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  logic [DLY_W-1:0] cntQ;
  logic [RES_W-1:0] sarQ;
  logic [RES_W-1:0] sarKeep;
  logic [RES_W-1:0] sarNext;
  logic [IDX_W-1:0] idxQ;
  logic [RES_W-1:0] resultQ;

  // Resolve the bit under trial, then arm the next lower one
  always_comb begin
    sarKeep       = sarQ;
    sarKeep[idxQ] = cmpIn;
    sarNext       = sarKeep;
    if (idxQ != '0) begin
      sarNext[idxQ - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      sarQ    <= '0;
      idxQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strb.loadDly) begin
        cntQ <= dlyVal;
      end else if (strb.decDly) begin
        cntQ <= cntQ - 1'b1;
      end

      if (strb.abort) begin
        sarQ <= '0;
        idxQ <= '0;
      end else if (strb.startConv) begin
        sarQ <= MSB_ONE;
        idxQ <= TOP_IDX;
      end else if (strb.stepConv) begin
        if (idxQ != '0) begin
          sarQ <= sarNext;
          idxQ <= idxQ - 1'b1;
        end else begin
          resultQ <= sarKeep;
          sarQ    <= '0;
        end
      end
    end
  end

  assign dlyZero = (cntQ == '0);
  assign lastBit = (idxQ == '0);
  assign trial   = sarQ;
  assign result  = resultQ;

  // R5
  msb_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startConv |=> (trial == MSB_ONE));

  // R10
  abort_clears_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (trial == '0));

endmodule

// File: rtl/sar_adc_ctl.sv
module sar_adc_ctl
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W   = 10,
  parameter int unsigned DLY_W   = 6,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DLY_RST = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              dlyZero,
  input  logic              lastBit,
  input  logic [RES_W-1:0]  result,
  output seqStrb_t          strb,
  output logic [DLY_W-1:0]  dlyVal,
  output logic [CHAN_W-1:0] chanSel,
  output logic              anaPwrEn,
  output logic              irqOut
);

  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              aligned;
  logic              hitCtrl;
  logic              hitDly;
  logic              wrCtrl;
  logic              wrDly;
  logic              newPwr;
  logic              startReq;
  logic              convDone;
  logic              busy;
  logic [24:0]       wdataUnused;

  seqState_t         stateQ;
  logic [CHAN_W-1:0] chanQ;
  logic              pwrQ;
  logic              ienQ;
  logic              doneQ;
  logic [DLY_W-1:0]  dlyQ;

  assign wordIdx     = busAddr[ADDR_W-1:2];
  assign aligned     = (busAddr[1:0] == 2'b00);
  assign hitCtrl     = aligned && (wordIdx == WIDX_W'(WORD_CTRL));
  assign hitDly      = aligned && (wordIdx == WIDX_W'(WORD_DELAY));
  assign wrCtrl      = busWr && hitCtrl;
  assign wrDly       = busWr && hitDly;
  assign newPwr      = busWdata[CTRL_PWR];
  assign wdataUnused = busWdata[31:7];

  assign startReq = wrCtrl && newPwr && !pwrQ;

  always_comb begin
    strb           = '0;
    strb.abort     = wrCtrl && !newPwr;
    strb.loadDly   = startReq;
    strb.decDly    = (stateQ == ST_WAIT) && !dlyZero && !strb.abort;
    strb.startConv = (stateQ == ST_WAIT) && dlyZero && !strb.abort;
    strb.stepConv  = (stateQ == ST_CONV) && !strb.abort;
  end

  assign convDone = strb.stepConv && lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      chanQ  <= '0;
      pwrQ   <= 1'b0;
      ienQ   <= 1'b0;
      doneQ  <= 1'b0;
      dlyQ   <= DLY_W'(DLY_RST);
    end else begin
      if (wrDly) begin
        dlyQ <= busWdata[DLY_W-1:0];
      end

      if (wrCtrl) begin
        chanQ <= busWdata[CHAN_W-1:0];
        ienQ  <= busWdata[CTRL_IEN];
        pwrQ  <= newPwr;
        if (!busWdata[CTRL_DONE] || !newPwr) begin
          doneQ <= 1'b0;
        end
      end

      if (convDone) begin
        doneQ <= 1'b1;
      end

      if (strb.abort) begin
        stateQ <= ST_IDLE;
      end else if (startReq) begin
        stateQ <= ST_WAIT;
      end else begin
        unique case (stateQ)
          ST_WAIT: if (dlyZero) stateQ <= ST_CONV;
          ST_CONV: if (lastBit) stateQ <= ST_IDLE;
          default: stateQ <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy = (stateQ != ST_IDLE);

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      unique case (wordIdx)
        WIDX_W'(WORD_RESULT): busRdata = 32'(result);
        WIDX_W'(WORD_STATUS): busRdata = {31'b0, busy};
        WIDX_W'(WORD_CTRL):   busRdata = {25'b0, doneQ, ienQ, 1'b0, pwrQ, chanQ};
        WIDX_W'(WORD_DELAY):  busRdata = 32'(dlyQ);
        default:              busRdata = '0;
      endcase
    end
  end

  assign dlyVal   = dlyQ;
  assign chanSel  = chanQ;
  assign anaPwrEn = pwrQ;
  assign irqOut   = doneQ && ienQ;

  // R3
  busy_needs_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> anaPwrEn);

  // R7
  done_after_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> ($past(stateQ) == ST_CONV) && !busy);

  // R10
  power_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anaPwrEn) |-> !busy && !doneQ);

  // R4
  wait_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (stateQ == ST_WAIT));

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W   = 10,
  parameter int unsigned DLY_W   = 6,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DLY_RST = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              cmpIn,
  output logic [RES_W-1:0]  trialCode,
  output logic [2:0]        chanSel,
  output logic              anaPwrEn,
  output logic              irqOut
);

  seqStrb_t         strb;
  logic [DLY_W-1:0] dlyVal;
  logic             dlyZero;
  logic             lastBit;
  logic [RES_W-1:0] result;

  sar_adc_ctl #(
    .RES_W  (RES_W),
    .DLY_W  (DLY_W),
    .ADDR_W (ADDR_W),
    .DLY_RST(DLY_RST)
  ) i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .dlyZero  (dlyZero),
    .lastBit  (lastBit),
    .result   (result),
    .strb     (strb),
    .dlyVal   (dlyVal),
    .chanSel  (chanSel),
    .anaPwrEn (anaPwrEn),
    .irqOut   (irqOut)
  );

  sar_adc_dp #(
    .RES_W(RES_W),
    .DLY_W(DLY_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dlyVal  (dlyVal),
    .cmpIn   (cmpIn),
    .dlyZero (dlyZero),
    .lastBit (lastBit),
    .trial   (trialCode),
    .result  (result)
  );

endmodule

// File: tb/test_sar_adc_seq.sv
module test_sar_adc_seq;

  localparam int CLK_P = 10;
  localparam int RES_W = 12;

  typedef struct packed {
    logic [2:0]  chan;
    logic [5:0]  dly;
    logic [11:0] vin;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 6'd8,  12'h000},
    '{3'd7, 6'd0,  12'hFFF},
    '{3'd3, 6'd1,  12'h800},
    '{3'd5, 6'd63, 12'h7FF},
    '{3'd1, 6'd2,  12'hA5A},
    '{3'd2, 6'd8,  12'h001}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busWr = 1'b0;
  logic [4:0]       busAddr = '0;
  logic [31:0]      busWdata = '0;
  logic [31:0]      busRdata;
  logic             cmpIn;
  logic [RES_W-1:0] trialCode;
  logic [2:0]       chanSel;
  logic             anaPwrEn;
  logic             irqOut;
  logic [RES_W-1:0] vin = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // Comparator model: high when the analog level is at or above the trial
  assign cmpIn = (trialCode <= vin);

  sar_adc_seq #(.RES_W(RES_W)) i_sar_adc_seq (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cmpIn(cmpIn),
    .trialCode(trialCode), .chanSel(chanSel), .anaPwrEn(anaPwrEn),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(5'h00, r); check("R1 result", r, 0);
    rd(5'h04, r); check("R1 status", r, 0);
    rd(5'h08, r); check("R1 ctrl", r, 0);
    rd(5'h0C, r); check("R1 delay", r, 8);
    check("R1 irq", irqOut, 0);
    check("R1 power", anaPwrEn, 0);
    check("R1 trial", trialCode, 0);

    // Table walk: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      vin = VECS[i].vin;
      wr(5'h0C, 32'(VECS[i].dly));
      wr(5'h08, 32'h28 | 32'(VECS[i].chan));
      check("R3 chanSel", chanSel, VECS[i].chan);
      check("R3 power", anaPwrEn, 1);
      busAddr = 5'h04;
      repeat (int'(VECS[i].dly) + RES_W) @(posedge clk);
      #1;
      check("R4 busy before end", busRdata, 1);
      check("R7 irq before end", irqOut, 0);
      @(posedge clk);
      #1;
      check("R4 busy after end", busRdata, 0);
      check("R8 irq at end", irqOut, 1);
      rd(5'h00, r); check("R6 result", r, 32'(VECS[i].vin));
      rd(5'h08, r); check("R7 ctrl done", r, 32'h68 | 32'(VECS[i].chan));
      wr(5'h08, 32'h28 | 32'(VECS[i].chan));
      check("R9 irq cleared", irqOut, 0);
      rd(5'h04, r); check("R3 no restart", r, 0);
      rd(5'h08, r); check("R9 ctrl", r, 32'h28 | 32'(VECS[i].chan));
      wr(5'h08, 0);
    end

    // R5 trial sequence: MSB first, then keep/drop per comparator
    vin = 12'h9C3;
    wr(5'h0C, 0);
    wr(5'h08, 32'h08);
    @(posedge clk); #1;
    check("R5 first trial", trialCode, 12'h800);
    @(posedge clk); #1;
    check("R5 second trial", trialCode, 12'hC00);
    @(posedge clk); #1;
    check("R5 third trial", trialCode, 12'hA00);
    wr(5'h08, 0);

    // R8 enable off: flag sets, no irq; R9 write-1 keeps flag
    vin = 12'h333;
    wr(5'h0C, 0);
    wr(5'h08, 32'h08);
    repeat (16) @(posedge clk);
    #1;
    check("R8 irq masked", irqOut, 0);
    rd(5'h08, r); check("R8 flag set", r, 32'h48);
    wr(5'h08, 32'h68);
    check("R9 write1 keeps", irqOut, 1);
    wr(5'h08, 32'h28);
    wr(5'h08, 32'h68);
    check("R9 no sw set", irqOut, 0);
    wr(5'h08, 0);

    // R10 abort during delay
    vin = 12'h444;
    wr(5'h0C, 20);
    wr(5'h08, 32'h28);
    repeat (5) @(posedge clk);
    wr(5'h08, 0);
    rd(5'h04, r); check("R10 busy after abort", r, 0);
    repeat (40) @(posedge clk);
    #1 check("R10 no irq", irqOut, 0);
    rd(5'h00, r); check("R10 result kept", r, 32'h333);

    // R10 abort during search
    wr(5'h0C, 0);
    wr(5'h08, 32'h28);
    repeat (4) @(posedge clk);
    rd(5'h04, r); check("R10 busy mid", r, 1);
    wr(5'h08, 0);
    check("R10 trial zero", trialCode, 0);
    rd(5'h04, r); check("R10 idle", r, 0);
    repeat (20) @(posedge clk);
    rd(5'h08, r); check("R10 ctrl zero", r, 0);
    rd(5'h00, r); check("R10 result kept mid", r, 32'h333);

    // R2 decode
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h09, 32'hFFFF_FFFF);
    rd(5'h10, r); check("R2 unmapped read", r, 0);
    rd(5'h1C, r); check("R2 unmapped read hi", r, 0);
    rd(5'h0A, r); check("R2 misaligned read", r, 0);
    rd(5'h08, r); check("R2 ctrl untouched", r, 0);
    rd(5'h0C, r); check("R2 delay untouched", r, 0);
    wr(5'h00, 32'h0000_0FFF);
    wr(5'h04, 32'h1);
    rd(5'h00, r); check("R2 result read-only", r, 32'h333);
    rd(5'h04, r); check("R2 status read-only", r, 0);
    check("R2 power off", anaPwrEn, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule